// File: doc/BRIEF.md
# Hierarchical Latched Interrupt Aggregator

This block gathers event pulses from several sub-units, from per-port buffer underrun detectors, from a clear-on-read status source and from a single change event. It turns them into one active-high interrupt line for a host CPU. Every event is caught in a latched status bit that holds until the CPU clears it. Each sub-unit owns a transmit group and a receive group of latched bits, and each group has a mask. A two-bit real-time summary per sub-unit and a global summary with one bit per sub-unit let the CPU walk down the hierarchy and find the source.

The CPU uses a single-cycle register bus. Read data is combinational from the address. A write takes effect at the clock edge on which the write strobe is high. Masks only gate the interrupt path, so masked bits can still be polled. Underrun information is held at two levels that are cleared independently: a per-port flag in the top pending register and a per-buffer register behind it.

Top module: `intagg_top`

## Requirements
- R1: A latched transmit or receive status bit sets on the edge at which its event input is high, and holds until a bus write with a 1 in that bit position. A 0 written to a position leaves that bit unchanged.
- R2: Mask bits block only the interrupt contribution. A masked status bit still latches and reads back as set.
- R3: Sub-unit summary (offset 4): bit 0 is high exactly while some unmasked transmit status bit is set, and bit 1 likewise for receive. Both are live and drop in the cycle after the last unmasked bit is cleared, without a separate clear.
- R4: The global summary register (address 0x03) has bit u high exactly while either summary bit of sub-unit u is high.
- R5: The irq output is registered. After each edge it equals the control enable bit (address 0x00, bit 0) ANDed with (any top pending bit whose top mask bit is 0, OR any global summary bit), all taken from the state before that edge.
- R6: If a top pending bit or a sub-unit status bit is already set while masked, clearing its mask asserts irq at the edge following the mask write, given the enable is set.
- R7: An underrun event on any buffer of port p sets top pending bit p (address 0x01) and the matching bit of that port's buffer register (address 0x08+p). Each level is write-1-to-clear, and clearing one level leaves the other unchanged.
- R8: The status register at 0x04 ORs in its event inputs and is cleared by a read; a read returns the content from before the clear. While it holds a nonzero value, top pending bit N_PORTS is set at every edge.
- R9: Top pending bit N_PORTS+1 sets on the change event and is cleared by writing 1 to it at address 0x01.
- R10: When an event coincides with a write-1 clear or a clearing read of its bit, the bit ends up 1.
- R11: After reset every status bit, every pending bit, the enable and irq are 0, and every mask bit is 1: the top mask at 0x02 and the sub-unit masks at offsets 1 and 3.
- R12: Register map. 0x00 control, 0x01 top pending, 0x02 top mask, 0x03 global summary (read-only), 0x04 clear-on-read status, and 0x08+p buffer underrun for port p. Sub-unit u has its base at 0x10+8u, with transmit status at +0, transmit mask at +1, receive status at +2, receive mask at +3 and summary at +4. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, one cycle per write |
| rd | input | 1 | Read strobe, needed for the clear-on-read side effect |
| rdata | output | 8 | Combinational read data for addr |
| tx_evt | input | N_UNITS*GRP_W | Transmit event pulses, sub-unit u at bits u*GRP_W upward |
| rx_evt | input | N_UNITS*GRP_W | Receive event pulses, same packing |
| urun_evt | input | N_PORTS*BUF_W | Buffer underrun pulses, port p at bits p*BUF_W upward |
| cor_evt | input | COR_W | Event inputs of the clear-on-read register |
| chg_evt | input | 1 | Change event pulse |
| irq | output | 1 | Registered active-high interrupt request |

## Verification
If a latched bit is wrong, it shows on the next read of its register. If it is unmasked, it also shows at the summary level in the same cycle, at the global summary, and on irq one edge later. A wrong mask or enable is seen only through irq, and always at the edge after the state changes. For that reason irq is compared against an expected value after every edge. Clear-on-read and set-wins corners are seen by reading the same register twice back to back and by reading the top pending register.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 6;
    localparam logic [ADDR_W-1:0] A_CTRL  = 6'h00;
    localparam logic [ADDR_W-1:0] A_PEND  = 6'h01;
    localparam logic [ADDR_W-1:0] A_PMASK = 6'h02;
    localparam logic [ADDR_W-1:0] A_GLOB  = 6'h03;
    localparam logic [ADDR_W-1:0] A_COR   = 6'h04;
    localparam int BUF_BASE  = 8;
    localparam int UNIT_BASE = 16;
    localparam int UNIT_STEP = 8;
    localparam int O_TX  = 0;
    localparam int O_TXM = 1;
    localparam int O_RX  = 2;
    localparam int O_RXM = 3;
    localparam int O_SUM = 4;
endpackage

// File: rtl/intagg_unit.sv
module intagg_unit #(
    parameter int GRP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_tx,
    input  logic             wr_txm,
    input  logic             wr_rx,
    input  logic             wr_rxm,
    input  logic [GRP_W-1:0] wdata,
    input  logic [GRP_W-1:0] tx_evt,
    input  logic [GRP_W-1:0] rx_evt,
    output logic [GRP_W-1:0] tx_lat,
    output logic [GRP_W-1:0] tx_msk,
    output logic [GRP_W-1:0] rx_lat,
    output logic [GRP_W-1:0] rx_msk,
    output logic [1:0]       sum
);
    typedef struct packed {
        logic [GRP_W-1:0] tx;
        logic [GRP_W-1:0] txm;
        logic [GRP_W-1:0] rx;
        logic [GRP_W-1:0] rxm;
    } unit_st_t;

    unit_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_tx)  s_d.tx = s_q.tx & ~wdata;
        if (wr_rx)  s_d.rx = s_q.rx & ~wdata;
        s_d.tx = s_d.tx | tx_evt;
        s_d.rx = s_d.rx | rx_evt;
        if (wr_txm) s_d.txm = wdata;
        if (wr_rxm) s_d.rxm = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.tx  <= '0;
            s_q.rx  <= '0;
            s_q.txm <= '1;
            s_q.rxm <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_lat = s_q.tx;
    assign tx_msk = s_q.txm;
    assign rx_lat = s_q.rx;
    assign rx_msk = s_q.rxm;
    assign sum[0] = |(s_q.tx & ~s_q.txm);
    assign sum[1] = |(s_q.rx & ~s_q.rxm);

    // R2: events latch whatever the mask holds
    p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_evt) |=> ((s_q.tx & $past(tx_evt)) == $past(tx_evt)));
    // R1: written ones clear when no event competes
    p_w1c_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && tx_evt == '0) |=> ((s_q.tx & $past(wdata)) == '0));
    // R1: no write and no event keeps the latched bits
    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_rx && rx_evt == '0) |=> $stable(s_q.rx));
    // R3: clearing all transmit bits drops the summary
    p_sum_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && wdata == '1 && tx_evt == '0) |=> !sum[0]);
endmodule

// File: rtl/intagg_port.sv
module intagg_port #(
    parameter int BUF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [BUF_W-1:0] wdata,
    input  logic [BUF_W-1:0] evt,
    output logic [BUF_W-1:0] lat
);
    logic [BUF_W-1:0] lat_d, lat_q;

    always_comb begin
        lat_d = wr_hit ? (lat_q & ~wdata) : lat_q;
        lat_d = lat_d | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign lat = lat_q;

    // R10: a coinciding clear never loses a new underrun
    p_urun_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((lat_q & $past(evt)) == $past(evt)));
    // R7: write-1 clears the buffer bits
    p_urun_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && evt == '0) |=> ((lat_q & $past(wdata)) == '0));
endmodule

// File: rtl/intagg_top.sv
module intagg_top
    import intagg_pkg::*;
#(
    parameter int N_UNITS = 2,
    parameter int GRP_W   = 8,
    parameter int N_PORTS = 2,
    parameter int BUF_W   = 4,
    parameter int COR_W   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     wr,
    input  logic                     rd,
    output logic [DATA_W-1:0]        rdata,
    input  logic [N_UNITS*GRP_W-1:0] tx_evt,
    input  logic [N_UNITS*GRP_W-1:0] rx_evt,
    input  logic [N_PORTS*BUF_W-1:0] urun_evt,
    input  logic [COR_W-1:0]         cor_evt,
    input  logic                     chg_evt,
    output logic                     irq
);
    localparam int TOP_W    = N_PORTS + 2;
    localparam int PEND_COR = N_PORTS;
    localparam int PEND_CHG = N_PORTS + 1;

    typedef struct packed {
        logic             en;
        logic [TOP_W-1:0] pend;
        logic [TOP_W-1:0] pmask;
        logic [COR_W-1:0] cor;
        logic             irq;
    } top_st_t;

    top_st_t s_d, s_q;

    logic [N_UNITS-1:0][GRP_W-1:0] u_tx, u_txm, u_rx, u_rxm;
    logic [N_UNITS-1:0][1:0]       u_sum;
    logic [N_UNITS-1:0]            glob;
    logic [N_PORTS-1:0][BUF_W-1:0] p_lat;

    for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
        localparam int BASE = UNIT_BASE + g * UNIT_STEP;
        intagg_unit #(.GRP_W(GRP_W)) u_unit (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_tx  (wr && addr == ADDR_W'(BASE + O_TX)),
            .wr_txm (wr && addr == ADDR_W'(BASE + O_TXM)),
            .wr_rx  (wr && addr == ADDR_W'(BASE + O_RX)),
            .wr_rxm (wr && addr == ADDR_W'(BASE + O_RXM)),
            .wdata  (wdata[GRP_W-1:0]),
            .tx_evt (tx_evt[g*GRP_W +: GRP_W]),
            .rx_evt (rx_evt[g*GRP_W +: GRP_W]),
            .tx_lat (u_tx[g]),
            .tx_msk (u_txm[g]),
            .rx_lat (u_rx[g]),
            .rx_msk (u_rxm[g]),
            .sum    (u_sum[g])
        );
        assign glob[g] = |u_sum[g];
    end

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        intagg_port #(.BUF_W(BUF_W)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hit (wr && addr == ADDR_W'(BUF_BASE + p)),
            .wdata  (wdata[BUF_W-1:0]),
            .evt    (urun_evt[p*BUF_W +: BUF_W]),
            .lat    (p_lat[p])
        );
    end

    always_comb begin
        s_d = s_q;
        if (wr && addr == A_CTRL)  s_d.en    = wdata[0];
        if (wr && addr == A_PEND)  s_d.pend  = s_q.pend & ~wdata[TOP_W-1:0];
        if (wr && addr == A_PMASK) s_d.pmask = wdata[TOP_W-1:0];
        for (int p = 0; p < N_PORTS; p++) begin
            s_d.pend[p] = s_d.pend[p] | (|urun_evt[p*BUF_W +: BUF_W]);
        end
        s_d.pend[PEND_COR] = s_d.pend[PEND_COR] | (s_q.cor != '0);
        s_d.pend[PEND_CHG] = s_d.pend[PEND_CHG] | chg_evt;
        s_d.cor = (rd && addr == A_COR) ? cor_evt : (s_q.cor | cor_evt);
        s_d.irq = s_q.en && ((|(s_q.pend & ~s_q.pmask)) || (|glob));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.en    <= 1'b0;
            s_q.pend  <= '0;
            s_q.pmask <= '1;
            s_q.cor   <= '0;
            s_q.irq   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irq = s_q.irq;

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata = DATA_W'(s_q.en);
            A_PEND:  rdata = DATA_W'(s_q.pend);
            A_PMASK: rdata = DATA_W'(s_q.pmask);
            A_GLOB:  rdata = DATA_W'(glob);
            A_COR:   rdata = DATA_W'(s_q.cor);
            default: rdata = '0;
        endcase
        for (int p = 0; p < N_PORTS; p++) begin
            if (addr == ADDR_W'(BUF_BASE + p)) rdata = DATA_W'(p_lat[p]);
        end
        for (int u = 0; u < N_UNITS; u++) begin
            if (addr == ADDR_W'(UNIT_BASE + u * UNIT_STEP + O_TX))  rdata = DATA_W'(u_tx[u]);
            if (addr == ADDR_W'(UNIT_BASE + u * UNIT_STEP + O_TXM)) rdata = DATA_W'(u_txm[u]);
            if (addr == ADDR_W'(UNIT_BASE + u * UNIT_STEP + O_RX))  rdata = DATA_W'(u_rx[u]);
            if (addr == ADDR_W'(UNIT_BASE + u * UNIT_STEP + O_RXM)) rdata = DATA_W'(u_rxm[u]);
            if (addr == ADDR_W'(UNIT_BASE + u * UNIT_STEP + O_SUM)) rdata = DATA_W'(u_sum[u]);
        end
    end

    // R5: a cleared enable keeps irq low at the next edge
    p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.en |=> !irq);
    // R6: an enabled, unmasked pending bit raises irq one edge later
    p_unmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en && (|(s_q.pend & ~s_q.pmask))) |=> irq);
    // R8: a clearing read leaves only the coinciding events
    p_cor_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && addr == A_COR) |=> (s_q.cor == $past(cor_evt)));
    // R8: nonzero content raises its top pending bit
    p_cor_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cor != '0) |=> s_q.pend[PEND_COR]);
    // R10: a change event beats a simultaneous clear
    p_chg_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        chg_evt |=> s_q.pend[PEND_CHG]);
endmodule

// File: tb/tb_intagg_top.sv
module tb_intagg_top;
    localparam int NU = 2;
    localparam int G  = 8;
    localparam int NP = 2;
    localparam int B  = 4;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic wr = 1'b0;
    logic rd = 1'b0;
    logic [7:0] rdata;
    logic [NU*G-1:0] tx_evt = '0;
    logic [NU*G-1:0] rx_evt = '0;
    logic [NP*B-1:0] urun_evt = '0;
    logic [CW-1:0] cor_evt = '0;
    logic chg_evt = 1'b0;
    logic irq;

    always #4 clk = ~clk;

    intagg_top dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
        .rdata(rdata), .tx_evt(tx_evt), .rx_evt(rx_evt), .urun_evt(urun_evt),
        .cor_evt(cor_evt), .chg_evt(chg_evt), .irq(irq)
    );

    logic [7:0] m_tx [NU];
    logic [7:0] m_txm[NU];
    logic [7:0] m_rx [NU];
    logic [7:0] m_rxm[NU];
    logic [3:0] m_buf[NP];
    logic [3:0] m_pend, m_pmask;
    logic [7:0] m_cor;
    logic m_en, m_irq;
    int n_chk = 0;
    int n_fail = 0;
    logic [5:0] alist[17];

    function automatic logic [1:0] msum(input int u);
        return {|(m_rx[u] & ~m_rxm[u]), |(m_tx[u] & ~m_txm[u])};
    endfunction

    function automatic logic [1:0] mglob();
        logic [1:0] gv;
        for (int u = 0; u < NU; u++) gv[u] = |msum(u);
        return gv;
    endfunction

    function automatic logic [7:0] mread(input logic [5:0] a);
        logic [7:0] v = '0;
        if (a == 6'h00) v = {7'b0, m_en};
        if (a == 6'h01) v = {4'b0, m_pend};
        if (a == 6'h02) v = {4'b0, m_pmask};
        if (a == 6'h03) v = {6'b0, mglob()};
        if (a == 6'h04) v = m_cor;
        for (int p = 0; p < NP; p++) if (a == 6'(8 + p)) v = {4'b0, m_buf[p]};
        for (int u = 0; u < NU; u++) begin
            if (a == 6'(16 + 8*u)) v = m_tx[u];
            if (a == 6'(17 + 8*u)) v = m_txm[u];
            if (a == 6'(18 + 8*u)) v = m_rx[u];
            if (a == 6'(19 + 8*u)) v = m_rxm[u];
            if (a == 6'(20 + 8*u)) v = {6'b0, msum(u)};
        end
        return v;
    endfunction

    function automatic string rtag(input logic [5:0] a);
        if (a == 6'h00) return "R12";
        if (a == 6'h01) return "R9";
        if (a == 6'h02) return "R11";
        if (a == 6'h03) return "R4";
        if (a == 6'h04) return "R8";
        if (a < 6'd16) return "R7";
        if (a[2:0] == 3'd4) return "R3";
        if (a[0]) return "R2";
        return "R1";
    endfunction

    task automatic mreset();
        for (int u = 0; u < NU; u++) begin
            m_tx[u] = '0; m_rx[u] = '0; m_txm[u] = '1; m_rxm[u] = '1;
        end
        for (int p = 0; p < NP; p++) m_buf[p] = '0;
        m_pend = '0; m_pmask = '1; m_cor = '0; m_en = 1'b0; m_irq = 1'b0;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h (addr %02h)", tag, act, exp, addr);
        end
    endtask

    // advance one clock; model computes next state from pre-edge state
    task automatic tick();
        logic [3:0] np;
        logic [7:0] nc;
        logic ni;
        ni = m_en && ((|(m_pend & ~m_pmask)) || (|mglob()));
        np = m_pend;
        if (wr && addr == 6'h01) np = np & ~wdata[3:0];
        for (int p = 0; p < NP; p++) np[p] = np[p] | (|urun_evt[p*B +: B]);
        np[2] = np[2] | (m_cor != 0);
        np[3] = np[3] | chg_evt;
        nc = (rd && addr == 6'h04) ? cor_evt : (m_cor | cor_evt);
        if (wr && addr == 6'h00) m_en = wdata[0];
        if (wr && addr == 6'h02) m_pmask = wdata[3:0];
        for (int p = 0; p < NP; p++) begin
            if (wr && addr == 6'(8 + p)) m_buf[p] = m_buf[p] & ~wdata[3:0];
            m_buf[p] = m_buf[p] | urun_evt[p*B +: B];
        end
        for (int u = 0; u < NU; u++) begin
            if (wr && addr == 6'(16 + 8*u)) m_tx[u] = m_tx[u] & ~wdata;
            if (wr && addr == 6'(18 + 8*u)) m_rx[u] = m_rx[u] & ~wdata;
            if (wr && addr == 6'(17 + 8*u)) m_txm[u] = wdata;
            if (wr && addr == 6'(19 + 8*u)) m_rxm[u] = wdata;
            m_tx[u] = m_tx[u] | tx_evt[u*G +: G];
            m_rx[u] = m_rx[u] | rx_evt[u*G +: G];
        end
        m_pend = np; m_cor = nc; m_irq = ni;
        @(posedge clk);
        @(negedge clk);
        check("R5", {7'b0, irq}, {7'b0, m_irq});
        wr = 1'b0; rd = 1'b0;
        tx_evt = '0; rx_evt = '0; urun_evt = '0; cor_evt = '0; chg_evt = 1'b0;
    endtask

    task automatic bus_wr(input logic [5:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick();
    endtask

    task automatic bus_rd(input logic [5:0] a, input string tag);
        addr = a; rd = 1'b1;
        #1;
        check(tag, rdata, mread(a));
        tick();
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        mreset();
        alist = '{6'h00, 6'h01, 6'h02, 6'h03, 6'h04, 6'h08, 6'h09,
                  6'h10, 6'h11, 6'h12, 6'h13, 6'h14, 6'h18, 6'h19, 6'h1A, 6'h1B, 6'h1C};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state of every register and irq
        check("R11", {7'b0, irq}, 8'h00);
        for (int i = 0; i < 17; i++) bus_rd(alist[i], "R11");

        // R2 masked bit still latches, summary and irq stay low
        bus_wr(6'h00, 8'h01);
        tx_evt[3] = 1'b1; tick();
        bus_rd(6'h10, "R2");
        bus_rd(6'h14, "R3");
        check("R2", {7'b0, irq}, 8'h00);
        // R6 unmasking a set bit raises irq at the next edge
        bus_wr(6'h11, 8'hF7);
        tick();
        check("R6", {7'b0, irq}, 8'h01);
        bus_rd(6'h03, "R4");
        // R1 writing zero keeps the bit, writing one clears it
        bus_wr(6'h10, 8'h00);
        bus_rd(6'h10, "R1");
        bus_wr(6'h10, 8'h08);
        bus_rd(6'h10, "R1");
        bus_rd(6'h14, "R3");
        // R9 and R10 change flag: set-wins then plain clear
        chg_evt = 1'b1; tick();
        addr = 6'h01; wdata = 8'h08; wr = 1'b1; chg_evt = 1'b1; tick();
        bus_rd(6'h01, "R10");
        bus_wr(6'h01, 8'h08);
        bus_rd(6'h01, "R9");
        // R8 clear-on-read and its pending flag
        cor_evt = 8'h5A; tick();
        bus_rd(6'h04, "R8");
        bus_rd(6'h04, "R8");
        bus_rd(6'h01, "R8");
        // R10 event during clearing read survives
        cor_evt = 8'h81; tick();
        addr = 6'h04; rd = 1'b1; cor_evt = 8'h02; #1;
        check("R10", rdata, mread(6'h04)); tick();
        bus_rd(6'h04, "R10");
        // R7 two-level underrun clearing
        urun_evt[6] = 1'b1; tick();
        bus_wr(6'h01, 8'h02);
        bus_rd(6'h01, "R7");
        bus_rd(6'h09, "R7");
        bus_wr(6'h09, 8'h04);
        bus_rd(6'h09, "R7");
        // R6 top-mask unmask of an already pending bit
        bus_wr(6'h02, 8'h0B);
        tick();
        check("R6", {7'b0, irq}, 8'h01);
        bus_wr(6'h00, 8'h00);
        tick();
        check("R5", {7'b0, irq}, 8'h00);

        // constrained random mix
        for (int c = 0; c < 6000; c++) begin
            int op;
            for (int b = 0; b < NU*G; b++) begin
                tx_evt[b] = ($urandom % 24) == 0;
                rx_evt[b] = ($urandom % 24) == 0;
            end
            for (int b = 0; b < NP*B; b++) urun_evt[b] = ($urandom % 24) == 0;
            for (int b = 0; b < CW; b++) cor_evt[b] = ($urandom % 32) == 0;
            chg_evt = ($urandom % 20) == 0;
            op = $urandom % 10;
            addr = alist[$urandom % 17];
            if (op < 4) begin
                wdata = 8'($urandom);
                if (addr == 6'h00) wdata[0] = ($urandom % 4) != 0;
                wr = 1'b1;
                tick();
            end else if (op < 8) begin
                rd = 1'b1; #1;
                check(rtag(addr), rdata, mread(addr));
                tick();
            end else begin
                tick();
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule